// File: doc/BRIEF.md
# Counting Semaphore Memory Bank

This block is a small bank of counting semaphores. A processor reaches it through ordinary loads and stores on a simple synchronous bus, so it needs no atomic instructions. Each word of the bank holds an unsigned counter.

A load from a counter word tries to take one unit. If the counter is above zero, the load decrements it and reports success. If it is zero, the load reports failure and the counter stays at zero. A store to a counter word gives one unit back, whatever the data. The test and the update for one access happen in a single clock edge, so no other access can come between them. Masters share the bus through an external arbiter.

The top address bit selects a configuration space:
- A store there loads a counter with a start value.
- A load there returns the sticky overflow flags without side effects.

Read responses come out on a valid-only channel, exactly one cycle after the load. The channel has no back-pressure: the requester must take the response in that cycle. The request side has no ready signal, because the bank takes one access per cycle.

Top module: `sem_bank`

## Requirements
- R1: While reset is held and after it is released, every counter is zero, every overflow flag is clear, and `rsp_valid` is low with `rsp_data` zero.
- R2: A load from counter word i (`bus_addr` top bit 0, index in the low bits) with a count above zero decrements the count by one. The response carries 1 in bit 0 and the decremented count in bits [CNT_W:1]. All higher bits are zero.
- R3: A load from a counter at zero returns bit 0 = 0 and count field 0, and the counter stays at zero.
- R4: A store to counter word i increments that count by one, whatever the value on `bus_wdata`.
- R5: A store to a counter at its maximum (all ones) leaves it at the maximum and sets overflow flag i. The flag then stays set until an init of that counter.
- R6: A load with the top address bit set returns the overflow flags, flag i in bit i, with zeros above them. It changes no counter and no flag.
- R7: A store with the top address bit set loads counter i with `bus_wdata[CNT_W-1:0]`, with no increment, and clears overflow flag i.
- R8: When load and store strobes arrive together on one counter word, the increment (saturating, with R5) is applied first. The take test and decrement of R2/R3 then act on the incremented value.
- R9: `rsp_valid` is high in exactly the cycle after each cycle with `bus_rd` high, and in no other cycle. Stores alone never produce a response.
- R10: An access changes only the counter and flag it addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | IDX_W+1 | Top bit selects configuration space; low bits select the counter |
| bus_rd | input | 1 | Load strobe: take (counter space) or flag read (configuration space) |
| bus_wr | input | 1 | Store strobe: give (counter space) or init (configuration space) |
| bus_wdata | input | DATA_W | Store data; only the init uses its low CNT_W bits |
| rsp_valid | output | 1 | Response valid, one cycle after a load, no back-pressure |
| rsp_data | output | DATA_W | Response word: success flag and count, or overflow flags |

## Verification
A counter holding a wrong value does not show at the ports until the next load of that word. That load then returns a wrong success bit or count field in the response one cycle later. A wrong count may also let a later store saturate too early or too late, which shows in the next flag read. The scoreboard therefore reads every counter back after long runs of mixed traffic, so that corrupted state left idle still surfaces. A wrong response timing shows at once as a response with no matching load, or a load left unanswered.

// File: rtl/sem_pkg.sv
package sem_pkg;

  // Per-counter action decoded from one bus access.
  typedef struct packed {
    logic give;  // store in counter space
    logic take;  // load in counter space
    logic init;  // store in configuration space
  } sem_act_t;

endpackage

// File: rtl/sem_decode.sv
module sem_decode
  import sem_pkg::*;
#(
  parameter int NUM_SEM = 8,
  parameter int IDX_W   = $clog2(NUM_SEM)
) (
  input  logic [IDX_W:0]               addr,
  input  logic                         rd,
  input  logic                         wr,
  output sem_act_t [NUM_SEM-1:0]       acts,
  output logic                         cfg_sel,
  output logic [IDX_W-1:0]             idx
);

  assign cfg_sel = addr[IDX_W];
  assign idx     = addr[IDX_W-1:0];

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_dec
    logic hit;
    assign hit          = (idx == IDX_W'(g));
    assign acts[g].give = hit && wr && !cfg_sel;
    assign acts[g].take = hit && rd && !cfg_sel;
    assign acts[g].init = hit && wr &&  cfg_sel;
  end

endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sem_act_t         act,
  input  logic [CNT_W-1:0] init_val,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_nxt,
  output logic             took,
  output logic             ovf
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] after_give;
  logic             sat_hit;
  logic             ovf_nxt;

  // Give is applied before the take test (same-cycle ordering).
  always_comb begin
    sat_hit    = act.give && (count == CNT_MAX);
    after_give = count;
    if (act.give && !sat_hit) after_give = count + CNT_W'(1);
    took       = act.take && (after_give != '0);
    count_nxt  = took ? after_give - CNT_W'(1) : after_give;
    ovf_nxt    = ovf | sat_hit;
    if (act.init) begin
      count_nxt = init_val;
      ovf_nxt   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      count <= count_nxt;
      ovf   <= ovf_nxt;
    end
  end

  // R3
  zero_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act.take && !act.give && !act.init && count == '0) |=> (count == '0));

  // R4
  give_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act.give && !act.take && !act.init && count != CNT_MAX)
      |=> (count == $past(count) + CNT_W'(1)));

  // R5
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act.give && !act.take && !act.init && count == CNT_MAX)
      |=> (count == CNT_MAX && ovf));

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !act.init) |=> ovf);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(act.give || act.take || act.init) |=> ($stable(count) && $stable(ovf)));

endmodule

// File: rtl/sem_resp.sv
module sem_resp #(
  parameter int NUM_SEM = 8,
  parameter int CNT_W   = 8,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = $clog2(NUM_SEM)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd,
  input  logic                          cfg_sel,
  input  logic [IDX_W-1:0]              idx,
  input  logic [NUM_SEM-1:0][CNT_W-1:0] counts_nxt,
  input  logic [NUM_SEM-1:0]            took_vec,
  input  logic [NUM_SEM-1:0]            ovf_vec,
  output logic                          rsp_valid,
  output logic [DATA_W-1:0]             rsp_data
);

  localparam int PAD_CNT = DATA_W - CNT_W - 1;
  localparam int PAD_OVF = DATA_W - NUM_SEM;

  logic [DATA_W-1:0] word;

  always_comb begin
    if (cfg_sel) word = {{PAD_OVF{1'b0}}, ovf_vec};
    else         word = {{PAD_CNT{1'b0}}, counts_nxt[idx], took_vec[idx]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd;
      rsp_data  <= rd ? word : '0;
    end
  end

  // R3
  fail_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !cfg_sel) |=> (rsp_data[0] || rsp_data[CNT_W:1] == '0));

endmodule

// File: rtl/sem_bank.sv
module sem_bank
  import sem_pkg::*;
#(
  parameter int NUM_SEM = 8,
  parameter int CNT_W   = 8,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W:0]    bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  sem_act_t [NUM_SEM-1:0]        acts;
  logic                          cfg_sel;
  logic [IDX_W-1:0]              idx;
  logic [NUM_SEM-1:0][CNT_W-1:0] counts;
  logic [NUM_SEM-1:0][CNT_W-1:0] counts_nxt;
  logic [NUM_SEM-1:0]            took_vec;
  logic [NUM_SEM-1:0]            ovf_vec;

  sem_decode #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) u_dec (
    .addr    (bus_addr),
    .rd      (bus_rd),
    .wr      (bus_wr),
    .acts    (acts),
    .cfg_sel (cfg_sel),
    .idx     (idx)
  );

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_cell
    sem_cell #(.CNT_W(CNT_W)) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .act       (acts[g]),
      .init_val  (bus_wdata[CNT_W-1:0]),
      .count     (counts[g]),
      .count_nxt (counts_nxt[g]),
      .took      (took_vec[g]),
      .ovf       (ovf_vec[g])
    );
  end

  sem_resp #(.NUM_SEM(NUM_SEM), .CNT_W(CNT_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd         (bus_rd),
    .cfg_sel    (cfg_sel),
    .idx        (idx),
    .counts_nxt (counts_nxt),
    .took_vec   (took_vec),
    .ovf_vec    (ovf_vec),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data)
  );

  // R9
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> rsp_valid);

  // R6
  status_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && cfg_sel) |=> ($stable(counts) && $stable(ovf_vec)));

endmodule

// File: tb/sem_bank_tb.sv
module sem_bank_tb;

  localparam int NUM_SEM = 8;
  localparam int CNT_W   = 8;
  localparam int DATA_W  = 32;
  localparam int IDX_W   = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [IDX_W:0]    bus_addr = '0;
  logic              bus_rd = 1'b0;
  logic              bus_wr = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_data;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [CNT_W-1:0]   m_cnt [NUM_SEM];
  logic [NUM_SEM-1:0] m_ovf;
  logic [DATA_W-1:0]  exp_q [$];
  string              tag_q [$];

  always #2 clk = ~clk;

  sem_bank #(.NUM_SEM(NUM_SEM), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data)
  );

  task automatic check(input bit ok, input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: one access per cycle, model updated, expected response queued.
  task automatic bus_op(input bit cfg, input int idx, input bit rd, input bit wr,
                        input logic [DATA_W-1:0] wd, input string tag);
    logic [DATA_W-1:0] exp;
    bit took;
    @(negedge clk);
    bus_addr  = {cfg, IDX_W'(idx)};
    bus_rd    = rd;
    bus_wr    = wr;
    bus_wdata = wd;
    exp = '0;
    if (rd && cfg) exp = DATA_W'(m_ovf);
    if (wr && !cfg) begin
      if (m_cnt[idx] == '1) m_ovf[idx] = 1'b1;
      else m_cnt[idx] = m_cnt[idx] + 1'b1;
    end
    if (wr && cfg) begin
      m_cnt[idx] = wd[CNT_W-1:0];
      m_ovf[idx] = 1'b0;
    end
    if (rd && !cfg) begin
      took = (m_cnt[idx] != '0);
      if (took) m_cnt[idx] = m_cnt[idx] - 1'b1;
      exp = {{(DATA_W-CNT_W-1){1'b0}}, m_cnt[idx], took};
    end
    if (rd) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_rd = 1'b0;
      bus_wr = 1'b0;
    end
  endtask

  // Monitor: compares each response against the scoreboard (R9 timing too).
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 response without load", rsp_data, '0);
      end else begin
        logic [DATA_W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_data === e, t, rsp_data, e);
      end
    end else if (rst_n && exp_q.size() > 1) begin
      check(1'b0, "R9 load left unanswered", '0, exp_q[0]);
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NUM_SEM; i++) m_cnt[i] = '0;
    m_ovf = '0;
    repeat (3) @(negedge clk);
    check({rsp_valid, rsp_data} == '0, "R1 outputs in reset", {31'b0, rsp_valid}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    check(rsp_valid == 1'b0, "R1 no response after reset", {31'b0, rsp_valid}, '0);

    bus_op(0, 0, 1, 0, 0, "R1 R3 counter zero after reset");
    bus_op(1, 0, 1, 0, 0, "R1 flags clear after reset");

    bus_op(0, 1, 0, 1, 32'hFFFF_FFFF, "R4 give");
    bus_op(0, 1, 0, 1, 32'h0000_0000, "R4 give");
    idle(3); // R9: stores alone give no response
    bus_op(0, 1, 1, 0, 0, "R2 take from 2");
    bus_op(0, 1, 1, 0, 0, "R2 take from 1");
    bus_op(0, 1, 1, 0, 0, "R3 take from 0 fails");
    bus_op(0, 1, 1, 0, 0, "R3 counter stays zero");

    bus_op(1, 2, 0, 1, 32'hABCD_0005, "R7 init");
    bus_op(0, 2, 1, 0, 0, "R7 R2 take after init 5");

    bus_op(1, 3, 0, 1, 32'h0000_00FF, "R7 init max");
    bus_op(0, 3, 0, 1, 32'h1234_5678, "R5 give at max");
    bus_op(1, 3, 1, 0, 0, "R5 R6 flag read");
    bus_op(1, 3, 1, 0, 0, "R6 flag read repeat");
    bus_op(0, 3, 1, 0, 0, "R5 R6 saturated count kept");
    bus_op(0, 4, 1, 1, 0, "R8 give then take at zero");
    bus_op(0, 3, 1, 1, 0, "R8 give then take at 254");
    bus_op(1, 3, 0, 1, 32'h0000_00FF, "R7 reinit max");
    bus_op(0, 3, 1, 1, 0, "R8 R5 saturate then take");
    bus_op(1, 0, 1, 0, 0, "R5 flag after joint access");
    bus_op(1, 3, 0, 1, 32'h0000_0007, "R7 init clears flag");
    bus_op(1, 0, 1, 0, 0, "R7 flag cleared");
    bus_op(1, 5, 1, 1, 32'h0000_0009, "R6 R7 read and init together");
    idle(2);

    for (int n = 0; n < 600; n++) begin
      int r;
      r = $urandom % 16;
      bus_op(r < 2, $urandom % NUM_SEM, r[0] | (r > 11), (r >= 6) && (r < 14),
             $urandom, "R10 mixed traffic");
      if (n % 97 == 0) bus_op(0, 6, 0, 1, 0, "R5 push toward max");
    end
    for (int i = 0; i < NUM_SEM; i++) bus_op(0, i, 1, 0, 0, "R10 final readback");
    bus_op(1, 0, 1, 0, 0, "R10 final flags");
    idle(4);
    check(exp_q.size() == 0, "R9 all loads answered", exp_q.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule